// File: doc/BRIEF.md
# Ready-Latency Packet Transmit Streamer

This block feeds the transmit side of a PCI Express transaction layer from the application. Upstream logic delivers packets as 64-bit beats on a plain valid/ready handshake, two dwords per beat with the lower dword in bits 31:0. Each packet is a header of three or four dwords, an optional alignment pad dword and the payload. The block itself works out where every packet ends from the header fields. It tags the first and last beat of each packet and drives the beats onto a streaming bus. That bus has no backpressure of its own: a sink ready, sampled a fixed number of cycles earlier, is the only thing that allows a beat.

The sink hangs if a packet pauses while it could accept data, or if a packet carries the wrong number of beats. To prevent the pause, the block buffers each packet completely before it releases the first beat. Once a packet has started, every cycle that the delayed ready allows carries one of its beats. The upstream side is held off through its own ready whenever the buffer is full. No start of packet is issued in the first two cycles after reset, even when the sink asserts ready during reset.

Top module: `tlp_tx_streamer`

## Requirements
- R1: `tx_valid` is low during reset and stays low in the first two cycles after reset is released, whatever `tx_ready` does during and after reset.
- R2: With ready latency L (parameter, 1 or 2, default 2), `tx_valid` may be high in cycle t only if `tx_ready` was high in cycle t-L. As a result, valid falls no later than L cycles after ready falls.
- R3: Between a beat with `tx_sop` and the beat with `tx_eop`, `tx_valid` is high in every cycle where `tx_ready` was high L cycles earlier. Within a packet, valid also resumes exactly L cycles after ready returns.
- R4: Header decode works on dword 0 of the packet: bit 30 set means the packet has a payload, bit 29 set means a four-dword header, and bits 9:0 are the payload length in dwords, with 0 meaning 1024. A pad dword is counted when the header is three dwords, a payload is present and bit 2 of dword 2 (address bit 2) is 0. The packet length in beats is ceil((header + pad + payload) / 2). Packets without a payload ignore the length field.
- R5: `tx_sop` is high on exactly the first beat of each packet and `tx_eop` on exactly its last beat.
- R6: Beats leave in the order they were accepted, with their data unchanged, and none is dropped or repeated.
- R7: An upstream beat is taken only in a cycle where `in_valid` and `in_ready` are both high. `in_ready` goes low while the buffer is full, and accepting continues once room is free.
- R8: The first beat of a packet is not presented before the last beat of that packet has been accepted upstream.
- R9: During reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | DATA_W | Upstream beat, lower dword in bits 31:0 |
| in_valid | input | 1 | Upstream beat present |
| in_ready | output | 1 | Block can take an upstream beat |
| tx_ready | input | 1 | Sink ready, effective L cycles later |
| tx_valid | output | 1 | Beat on the transmit bus |
| tx_data | output | DATA_W | Transmit beat |
| tx_sop | output | 1 | First beat of a packet |
| tx_eop | output | 1 | Last beat of a packet |

## Verification
The bench targets header decode at its edges. These cases are a packet without payload whose length field is non-zero, the length value 0 standing for 1024 dwords, and three-dword headers on both values of address bit 2. A design that decodes any of these wrongly shifts the end-of-packet marker, and every later comparison then fails. A long stretch with ready low fills the buffer and tests upstream stalling: a design that overwrites or skips entries loses or repeats dwords against the reference queue. Slow upstream delivery mixed with a toggling ready tests the no-bubble rule and the full-packet-before-start rule. A design that starts a packet early stalls mid-packet, and one that ignores the latency pipeline drives valid in cycles the sink never allowed.

// File: rtl/tlp_tx_pkg.sv
package tlp_tx_pkg;

  localparam int unsigned FULL_LEN_DW = 1024;

  // Beats occupied by one packet, given its decoded header fields.
  function automatic int unsigned pkt_beats(input logic has_pay, input logic hdr4,
                                            input logic [9:0] len, input logic addr_b2,
                                            input int unsigned dw_per_beat);
    int unsigned pay;
    int unsigned hdr;
    int unsigned pad;
    pay = has_pay ? ((len == 10'd0) ? FULL_LEN_DW : 32'(len)) : 32'd0;
    hdr = hdr4 ? 32'd4 : 32'd3;
    pad = (has_pay && !hdr4 && !addr_b2) ? 32'd1 : 32'd0;
    return (hdr + pad + pay + dw_per_beat - 1) / dw_per_beat;
  endfunction

endpackage

// File: rtl/tlp_beat_framer.sv
module tlp_beat_framer #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] beat,
  input  logic              take,
  output logic              first,
  output logic              last
);
  import tlp_tx_pkg::*;

  localparam int unsigned DPB       = DATA_W / 32;
  localparam int unsigned A2_BEAT   = 2 / DPB;
  localparam int unsigned A2_LANE   = 2 % DPB;
  localparam int unsigned MAX_BEATS = (4 + 1 + FULL_LEN_DW + DPB - 1) / DPB;
  localparam int unsigned IDX_W     = $clog2(MAX_BEATS + 1);

  logic [IDX_W-1:0] idx_q;
  logic [31:0]      dw0_q;
  logic             a2_q;
  logic [31:0]      dw0;
  logic             a2;
  int unsigned      total;

  always_comb begin
    dw0   = (idx_q == '0) ? beat[31:0] : dw0_q;
    a2    = (idx_q == IDX_W'(A2_BEAT)) ? beat[A2_LANE*32+2] : a2_q;
    total = pkt_beats(dw0[30], dw0[29], dw0[9:0], a2, DPB);
    first = (idx_q == '0);
    last  = (32'(idx_q) + 32'd1 == total);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      dw0_q <= '0;
      a2_q  <= 1'b0;
    end else if (take) begin
      if (idx_q == '0) dw0_q <= beat[31:0];
      if (idx_q == IDX_W'(A2_BEAT)) a2_q <= beat[A2_LANE*32+2];
      idx_q <= last ? '0 : idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/tlp_pkt_fifo.sv
module tlp_pkt_fifo #(
  parameter int unsigned W     = 66,
  parameter int unsigned DEPTH = 1024
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       wr_last,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_q,
  input  logic                       pkt_gone,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] pkts
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] fill;

  assign full  = (fill == CW'(DEPTH));
  assign empty = (fill == '0);

  // Storage and registered read port, no reset, so it maps to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
    if (rd_en) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      fill <= '0;
      pkts <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      fill <= fill + CW'(wr_en) - CW'(rd_en);
      pkts <= pkts + CW'(wr_en && wr_last) - CW'(pkt_gone);
    end
  end

endmodule

// File: rtl/tlp_ready_pacer.sv
module tlp_ready_pacer #(
  parameter int unsigned READY_LAT   = 2,
  parameter int unsigned STARTUP_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_ready,
  output logic permit,
  output logic started
);
  localparam int unsigned SW = $clog2(STARTUP_CYC + 1);

  logic [SW-1:0] cnt;

  generate
    if (READY_LAT == 1) begin : g_lat1
      assign permit = tx_ready;
    end else begin : g_latn
      logic [READY_LAT-2:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= (READY_LAT-1)'({sh, tx_ready});
      end
      assign permit = sh[READY_LAT-2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                          cnt <= '0;
    else if (cnt != SW'(STARTUP_CYC)) cnt <= cnt + 1'b1;
  end

  assign started = (cnt == SW'(STARTUP_CYC));

endmodule

// File: rtl/tlp_tx_streamer.sv
module tlp_tx_streamer #(
  parameter int unsigned DATA_W      = 64,
  parameter int unsigned READY_LAT   = 2,
  parameter int unsigned FIFO_DEPTH  = 1024,
  parameter int unsigned STARTUP_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop
);
  localparam int unsigned W  = DATA_W + 2;
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);

  logic          take, first, last;
  logic          full, empty;
  logic [W-1:0]  rd_q;
  logic [CW-1:0] pkts;
  logic          permit, started;
  logic          valid_q, mid_q, mid, gone, avail, send;

  assign take     = in_valid && in_ready;
  assign in_ready = !full;

  tlp_beat_framer #(.DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst(rst), .beat(in_data), .take(take), .first(first), .last(last)
  );

  tlp_pkt_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .wr_en(take), .wr_data({first, last, in_data}), .wr_last(last),
    .rd_en(send), .rd_q(rd_q), .pkt_gone(gone),
    .full(full), .empty(empty), .pkts(pkts)
  );

  tlp_ready_pacer #(.READY_LAT(READY_LAT), .STARTUP_CYC(STARTUP_CYC)) u_pacer (
    .clk(clk), .rst(rst), .tx_ready(tx_ready), .permit(permit), .started(started)
  );

  assign tx_valid = valid_q;
  assign tx_data  = rd_q[DATA_W-1:0];
  assign tx_eop   = rd_q[DATA_W];
  assign tx_sop   = rd_q[DATA_W+1];

  always_comb begin
    gone  = valid_q && tx_eop;
    mid   = valid_q ? !tx_eop : mid_q;
    avail = (pkts > CW'(gone));
    send  = permit && !empty && (mid || (avail && started));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      mid_q   <= 1'b0;
    end else begin
      valid_q <= send;
      mid_q   <= mid;
    end
  end

endmodule

// File: rtl/tlp_tx_streamer_chk.sv
module tlp_tx_streamer_chk #(
  parameter int unsigned READY_LAT   = 2,
  parameter int unsigned STARTUP_CYC = 2
) (
  input logic clk,
  input logic rst,
  input logic tx_ready,
  input logic tx_valid,
  input logic tx_sop,
  input logic tx_eop
);
  logic [7:0] since;
  logic       open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      since  <= '0;
      open_q <= 1'b0;
    end else begin
      if (since != 8'hff) since <= since + 1'b1;
      if (tx_valid) open_q <= !tx_eop;
    end
  end

  // R1
  startup_hold_chk: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (since >= 8'(STARTUP_CYC)));

  // R2
  ready_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && since >= 8'(READY_LAT)) |-> $past(tx_ready, READY_LAT));

  // R3
  no_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (open_q && since >= 8'(READY_LAT) && $past(tx_ready, READY_LAT)) |-> tx_valid);

  // R5
  sop_outside_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_sop) |-> !open_q);

  // R5
  body_inside_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_sop) |-> open_q);

endmodule

bind tlp_tx_streamer tlp_tx_streamer_chk #(.READY_LAT(READY_LAT), .STARTUP_CYC(STARTUP_CYC)) u_chk (
  .clk(clk), .rst(rst), .tx_ready(tx_ready), .tx_valid(tx_valid),
  .tx_sop(tx_sop), .tx_eop(tx_eop)
);

// File: tb/test_tlp_tx_streamer.sv
module test_tlp_tx_streamer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        tx_ready = 1'b1;
  logic        tx_valid, tx_sop, tx_eop;
  logic [63:0] tx_data;

  int compared = 0, mismatched = 0;
  logic [63:0] in_q[$];
  logic [65:0] exp_q[$];
  int   beats_q[$];
  int   in_rate = 100, rdy_mode = 0, since = -1;
  int   acc_in_pkt = 0, pkts_in = 0, pkts_out = 0;
  bit   open = 0, rh1 = 0, rh2 = 0, saw_full = 0, done = 0;

  always #2 clk = ~clk;

  tlp_tx_streamer i_tlp_tx_streamer (
    .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop)
  );

  task automatic chk(input bit ok, input string s);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s", s);
    end
  endtask

  function automatic int exp_beats(bit has_pay, bit hdr4, logic [9:0] len, bit a2);
    int dws;
    dws = hdr4 ? 4 : 3;
    if (has_pay) dws += (len == 0 ? 1024 : int'(len)) + ((!hdr4 && !a2) ? 1 : 0);
    return (dws + 1) / 2;
  endfunction

  task automatic make_pkt(input bit has_pay, input bit hdr4, input logic [9:0] len, input bit a2);
    logic [31:0] dws[$];
    int n;
    n = exp_beats(has_pay, hdr4, len, a2);
    dws.push_back({1'b0, has_pay, hdr4, 19'($urandom), len});
    dws.push_back($urandom);
    dws.push_back({29'($urandom), a2, 2'b00});
    if (hdr4) dws.push_back($urandom);
    while (dws.size() < 2 * n) dws.push_back($urandom);
    for (int i = 0; i < n; i++) begin
      in_q.push_back({dws[2*i+1], dws[2*i]});
      exp_q.push_back({(i == 0), (i == n - 1), dws[2*i+1], dws[2*i]});
    end
    beats_q.push_back(n);
  endtask

  task automatic rand_pkt(input int maxlen);
    make_pkt($urandom % 4 != 0, $urandom % 2, 10'(1 + $urandom % maxlen), $urandom % 2);
  endtask

  task automatic drain();
    for (int i = 0; i < 20000 && exp_q.size() != 0; i++) @(posedge clk);
  endtask

  // upstream driver (R7)
  initial forever begin
    @(posedge clk); #1;
    if (!rst && in_q.size() != 0 && ($urandom % 100) < in_rate) begin
      in_valid = 1'b1;
      in_data  = in_q[0];
    end else in_valid = 1'b0;
    @(negedge clk);
    if (in_valid && !in_ready) saw_full = 1;
    if (in_valid && in_ready) begin
      void'(in_q.pop_front());
      acc_in_pkt++;
      if (acc_in_pkt == beats_q[0]) begin
        void'(beats_q.pop_front());
        acc_in_pkt = 0;
        pkts_in++;
      end
    end
  end

  // sink ready driver
  initial forever begin
    @(posedge clk); #1;
    case (rdy_mode)
      0: tx_ready = 1'b1;
      1: tx_ready = ($urandom % 100) < 60;
      default: tx_ready = 1'b0;
    endcase
  end

  // output monitor
  always @(negedge clk) begin
    if (!rst) begin
      since++;
      if (tx_valid) begin
        chk(since >= 2, $sformatf("R1 valid at cycle act=%0d exp>=2", since));
        chk(rh2, $sformatf("R2 valid without ready two cycles earlier act=%0b exp=1", rh2));
        if (exp_q.size() == 0) chk(0, $sformatf("R6 extra beat act=%h exp=none", tx_data));
        else begin
          logic [65:0] e;
          e = exp_q.pop_front();
          chk(tx_data == e[63:0], $sformatf("R6 data act=%h exp=%h", tx_data, e[63:0]));
          chk({tx_sop, tx_eop} == e[65:64],
              $sformatf("R5 sop/eop act=%b exp=%b (R4 beat count)", {tx_sop, tx_eop}, e[65:64]));
        end
        if (tx_sop) begin
          chk(pkts_out < pkts_in, $sformatf("R8 start before fully accepted act=%0d exp<%0d", pkts_out, pkts_in));
          pkts_out++;
        end
      end else if (open && rh2) begin
        chk(0, "R3 bubble inside packet act=0 exp=1");
      end
      if (tx_valid) open = !tx_eop;
      rh2 = rh1;
      rh1 = tx_ready;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired act=running exp=finished");
    finish_run();
  end

  initial begin
    // directed header cases, loaded during reset with ready high (R1, R4)
    make_pkt(0, 0, 10'd7, 0);   // 3DW no payload: 2 beats
    make_pkt(0, 1, 10'd5, 1);   // 4DW no payload, length ignored: 2 beats
    make_pkt(1, 0, 10'd1, 0);   // 3DW aligned with pad: 3 beats
    make_pkt(1, 0, 10'd1, 1);   // 3DW unaligned: 2 beats
    make_pkt(1, 1, 10'd3, 1);   // 4DW: 4 beats
    make_pkt(1, 0, 10'd0, 0);   // 1024 dwords: 514 beats
    make_pkt(1, 1, 10'd0, 1);   // 4DW 1024 dwords: 514 beats
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(tx_valid == 0, $sformatf("R1 valid in reset act=%b exp=0", tx_valid));
    chk(in_ready == 1, $sformatf("R9 in_ready in reset act=%b exp=1", in_ready));
    @(posedge clk); #1 rst = 1'b0;
    drain();
    chk(exp_q.size() == 0, $sformatf("R4 directed beats left act=%0d exp=0", exp_q.size()));

    // random traffic with random sink ready (R2, R3, R6)
    rdy_mode = 1;
    for (int i = 0; i < 80; i++) rand_pkt(32);
    drain();
    chk(exp_q.size() == 0, $sformatf("R6 random beats left act=%0d exp=0", exp_q.size()));

    // sink stalled long enough to fill the buffer (R7)
    rdy_mode = 2;
    for (int i = 0; i < 70; i++) rand_pkt(100);
    repeat (1500) @(posedge clk);
    chk(saw_full, $sformatf("R7 upstream stalled act=%0b exp=1", saw_full));
    rdy_mode = 1;
    drain();
    chk(exp_q.size() == 0 && in_q.size() == 0,
        $sformatf("R7 beats after stall act=%0d exp=0", exp_q.size() + in_q.size()));

    // slow upstream, toggling sink (R3, R8)
    in_rate = 30;
    for (int i = 0; i < 40; i++) rand_pkt(24);
    drain();
    chk(exp_q.size() == 0, $sformatf("R3 slow-source beats left act=%0d exp=0", exp_q.size()));
    chk(pkts_out == pkts_in, $sformatf("R6 packet count act=%0d exp=%0d", pkts_out, pkts_in));
    repeat (10) @(posedge clk);
    finish_run();
  end

endmodule